// File: doc/BRIEF.md
# Smart-card slave register interface

This block is the register front end of a card-side smart-card byte interface. A processor reaches it through a simple 32-bit register bus. Each access carries an address, a write enable, write data and a read strobe, and read data comes back in the same cycle. On the line side the block takes whole received bytes (valid plus data) and hands out bytes to transmit (valid plus data). A ready output tells the line side when a byte may be delivered. A single level interrupt reports any enabled status condition.

Every register has its own reset value and its own mask of writable bits. The buffer and status registers have side effects. A received byte lands in the buffer and raises the receive-full flag, or the overrun flag if the buffer was still full. Reading the buffer drops receive-full. The two error flags are cleared by writing a 1 to them. While the control register selects transmit mode, a write to the buffer or baud offset sends its low byte out on the transmit port and is not stored. The DMA-descriptor and timer registers are masked storage only. Line framing, baud generation, DMA transfers and timer counting live in other blocks.

Top module: `scs_regif`

## Requirements
- R1: After reset the registers read as follows. Control (0x00) 0x01, control1 (0x04) 0x07, control2 (0x08) 0x00, status (0x0C) 0x01, baud (0x10) 0x01, buffer (0x14) 0x00, direction (0x18) 0x01, interrupt mask (0x1C) 0x00. DMA control (0x30), status (0x34), address (0x38), length (0x3C) and pointer (0x40) all read 0x00, and DMA mask (0x44) reads 0x07. Timer control (0x50), data (0x54) and reload (0x58) read 0x00, timer mask (0x5C) 0x01, and null byte (0x60) 0x60. The interrupt is low and rx_ready is high.
- R2: A write changes only the writable bits of a register, which are:
  - control: bits 7 and 5; control1: 0x3F; control2: 0x85; interrupt mask: 0x8F;
  - direction and DMA control: 0x03; DMA status and DMA mask: 0x07; DMA address: 0xFFFFFF; DMA length: 0x1FF;
  - timer control: 0x0F; timer data and reload: 0xFFFF; timer mask: 0x01; null byte: 0xFF;
  - buffer and baud: 0xFF, outside transmit mode only.
  The DMA pointer cannot be written.
- R3: An accepted received byte (rx_valid with rx_ready high) is stored in the buffer at the clock edge. It sets status bit 1 (receive full) when that bit was clear. Reading offset 0x14 returns the byte and clears status bit 1.
- R4: A byte accepted while status bit 1 is set still overwrites the buffer, leaves bit 1 set and sets status bit 3 (overrun).
- R5: Writing 1 to status bit 3 or bit 2 clears that flag. Status bit 0 (transmit buffer empty) always reads 1, and status bit 1 cannot be changed by a status write.
- R6: While control bit 5 (transmit mode) is 1, rx_ready is low and rx_valid has no effect on the buffer or the status register.
- R7: In transmit mode a write to offset 0x14 or 0x10 drives tx_valid high for exactly the cycle after the write edge, with tx_data equal to the low byte written. The buffer and baud contents do not change, and control bit 4 reads 0 afterwards.
- R8: irq is high exactly when some bit is set in both the status register and the interrupt mask. It follows every change of either register from the next cycle on.
- R9: An access with address bits 1:0 not zero reads 0 and has no effect. A write changes nothing, and a read of 0x15 does not clear receive full.
- R10: Offsets that hold no register (for example 0x20, 0x48, 0x7C) read 0 and ignore writes.
- R11: A buffer read in the same cycle as an accepted byte returns the old byte and does not clear receive full. If receive full was already set, overrun is set as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; a buffer read clears receive full at the edge |
| bus_rdata | output | 32 | Read data for bus_addr in the same cycle |
| rx_valid | input | 1 | A received byte is offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Bytes are accepted (low in transmit mode) |
| tx_valid | output | 1 | One-cycle pulse: a byte to transmit |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt: status AND mask is non-zero |

## Verification
Writes, accepted bytes and buffer read-clears all take effect at the rising edge that samples them. The bench drives stimulus at the falling edge and checks the effect through a read-back in a later cycle. Read data is combinational from the registers, so each read is sampled just after its address settles, before the edge that would apply a read-clear. tx_valid and irq come from state updated at the write or receive edge, so they are checked at the falling edge just after it. The following cycle confirms that the transmit pulse has dropped.

// File: rtl/scs_pkg.sv
package scs_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int NSLOTS = 2 ** (ADDR_W - 2);

    // word slots (offset / 4); positions are decoded by software
    localparam int SLOT_CTRL    = 0;
    localparam int SLOT_CTRL1   = 1;
    localparam int SLOT_CTRL2   = 2;
    localparam int SLOT_STS     = 3;
    localparam int SLOT_BAUD    = 4;
    localparam int SLOT_BUF     = 5;
    localparam int SLOT_DIR     = 6;
    localparam int SLOT_IMSK    = 7;
    localparam int SLOT_DMA_CTL = 12;
    localparam int SLOT_DMA_STS = 13;
    localparam int SLOT_DMA_ADR = 14;
    localparam int SLOT_DMA_LEN = 15;
    localparam int SLOT_DMA_PTR = 16;
    localparam int SLOT_DMA_MSK = 17;
    localparam int SLOT_TMR_CTL = 20;
    localparam int SLOT_TMR_DAT = 21;
    localparam int SLOT_TMR_RLD = 22;
    localparam int SLOT_TMR_MSK = 23;
    localparam int SLOT_NULL    = 24;

    localparam int CTRL_TXACT_BIT = 4;
    localparam int CTRL_TXMODE_BIT = 5;

    typedef struct packed {
        logic ovr;   // bit 3
        logic perr;  // bit 2
        logic rbf;   // bit 1
        logic tbe;   // bit 0
    } flags_t;

    typedef struct packed {
        logic                 wr;
        logic                 rd;
        logic [ADDR_W-3:0]    slot;
    } access_t;

    function automatic logic [DATA_W-1:0] slot_mask(int idx);
        case (idx)
            SLOT_CTRL:    return 32'h0000_00A0;
            SLOT_CTRL1:   return 32'h0000_003F;
            SLOT_CTRL2:   return 32'h0000_0085;
            SLOT_BAUD:    return 32'h0000_00FF;
            SLOT_BUF:     return 32'h0000_00FF;
            SLOT_DIR:     return 32'h0000_0003;
            SLOT_IMSK:    return 32'h0000_008F;
            SLOT_DMA_CTL: return 32'h0000_0003;
            SLOT_DMA_STS: return 32'h0000_0007;
            SLOT_DMA_ADR: return 32'h00FF_FFFF;
            SLOT_DMA_LEN: return 32'h0000_01FF;
            SLOT_DMA_MSK: return 32'h0000_0007;
            SLOT_TMR_CTL: return 32'h0000_000F;
            SLOT_TMR_DAT: return 32'h0000_FFFF;
            SLOT_TMR_RLD: return 32'h0000_FFFF;
            SLOT_TMR_MSK: return 32'h0000_0001;
            SLOT_NULL:    return 32'h0000_00FF;
            default:      return 32'h0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] slot_reset(int idx);
        case (idx)
            SLOT_CTRL, SLOT_BAUD, SLOT_DIR, SLOT_TMR_MSK: return 32'h1;
            SLOT_CTRL1, SLOT_DMA_MSK:                     return 32'h7;
            SLOT_NULL:                                    return 32'h60;
            default:                                      return 32'h0;
        endcase
    endfunction

    function automatic bit slot_mapped(int idx);
        return (idx <= SLOT_IMSK) ||
               (idx >= SLOT_DMA_CTL && idx <= SLOT_DMA_MSK) ||
               (idx >= SLOT_TMR_CTL && idx <= SLOT_NULL);
    endfunction

    // plain masked storage: no side effects
    function automatic bit slot_plain(int idx);
        return slot_mapped(idx) && idx != SLOT_CTRL && idx != SLOT_STS &&
               idx != SLOT_BAUD && idx != SLOT_BUF;
    endfunction

endpackage

// File: rtl/scs_mask_reg.sv
module scs_mask_reg
    import scs_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST = '0,
    parameter logic [DATA_W-1:0] MSK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] clr,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = we ? ((q & ~MSK) | (wdata & MSK)) : q;
        nxt = nxt & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST;
        else     q <= nxt;
    end
endmodule

// File: rtl/scs_flags.sv
module scs_flags
    import scs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_fire,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              buf_we,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              sts_we,
    input  logic [1:0]        sts_w1c,   // write data bits 3:2
    output logic [BYTE_W-1:0] buf_q,
    output flags_t            flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            flags <= '{ovr: 1'b0, perr: 1'b0, rbf: 1'b0, tbe: 1'b1};
        end else begin
            if (rx_fire)      buf_q <= rx_byte;
            else if (buf_we)  buf_q <= buf_wdata;

            if (rx_fire)      flags.rbf <= 1'b1;
            else if (buf_rd)  flags.rbf <= 1'b0;

            if (rx_fire && flags.rbf)       flags.ovr <= 1'b1;
            else if (sts_we && sts_w1c[1])  flags.ovr <= 1'b0;

            if (sts_we && sts_w1c[0])       flags.perr <= 1'b0;

            flags.tbe <= 1'b1;
        end
    end

    // R4: byte on a full buffer raises overrun
    a_r4_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (rx_fire && flags.rbf) |=> flags.ovr);

    // R3: a lone buffer read empties the buffer flag
    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && !rx_fire) |=> !flags.rbf);

    // R3: an accepted byte lands in the buffer
    a_r3_byte_stored: assert property (@(posedge clk) disable iff (rst)
        rx_fire |=> (buf_q == $past(rx_byte)) && flags.rbf);
endmodule

// File: rtl/scs_regif.sv
module scs_regif
    import scs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [6:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    access_t            acc;
    logic               aligned;
    logic               tx_mode;
    logic               tx_fire;
    logic               rx_fire;
    logic [DATA_W-1:0]  slot_q [NSLOTS];
    logic [BYTE_W-1:0]  buf_q;
    flags_t             flags;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        acc.wr   = bus_we & aligned;
        acc.rd   = bus_re & aligned;
        acc.slot = bus_addr[ADDR_W-1:2];
    end

    assign tx_mode  = slot_q[SLOT_CTRL][CTRL_TXMODE_BIT];
    assign rx_ready = !tx_mode;
    assign rx_fire  = rx_valid & rx_ready;
    assign tx_fire  = acc.wr & tx_mode &
                      (acc.slot == SLOT_BUF[ADDR_W-3:0] || acc.slot == SLOT_BAUD[ADDR_W-3:0]);

    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        localparam logic [ADDR_W-3:0] IDX = i[ADDR_W-3:0];
        if (slot_plain(i)) begin : g_plain
            scs_mask_reg #(.RST(slot_reset(i)), .MSK(slot_mask(i))) u_reg (
                .clk(clk), .rst(rst),
                .we(acc.wr && acc.slot == IDX),
                .wdata(bus_wdata), .clr('0), .q(slot_q[i]));
        end else if (i == SLOT_CTRL) begin : g_ctrl
            scs_mask_reg #(.RST(slot_reset(i)), .MSK(slot_mask(i))) u_reg (
                .clk(clk), .rst(rst),
                .we(acc.wr && acc.slot == IDX),
                .wdata(bus_wdata),
                .clr(tx_fire ? DATA_W'(1 << CTRL_TXACT_BIT) : '0),
                .q(slot_q[i]));
        end else if (i == SLOT_BAUD) begin : g_baud
            scs_mask_reg #(.RST(slot_reset(i)), .MSK(slot_mask(i))) u_reg (
                .clk(clk), .rst(rst),
                .we(acc.wr && acc.slot == IDX && !tx_mode),
                .wdata(bus_wdata), .clr('0), .q(slot_q[i]));
        end else if (i == SLOT_STS) begin : g_sts
            assign slot_q[i] = DATA_W'(flags);
        end else if (i == SLOT_BUF) begin : g_buf
            assign slot_q[i] = DATA_W'(buf_q);
        end else begin : g_hole
            assign slot_q[i] = '0;
        end
    end

    scs_flags u_flags (
        .clk(clk), .rst(rst),
        .rx_fire(rx_fire), .rx_byte(rx_data),
        .buf_we(acc.wr && acc.slot == SLOT_BUF[ADDR_W-3:0] && !tx_mode),
        .buf_wdata(bus_wdata[BYTE_W-1:0]),
        .buf_rd(acc.rd && acc.slot == SLOT_BUF[ADDR_W-3:0]),
        .sts_we(acc.wr && acc.slot == SLOT_STS[ADDR_W-3:0]),
        .sts_w1c(bus_wdata[3:2]),
        .buf_q(buf_q), .flags(flags));

    assign bus_rdata = aligned ? slot_q[acc.slot] : '0;
    assign irq       = |(slot_q[SLOT_STS] & slot_q[SLOT_IMSK]);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= tx_fire;
            if (tx_fire) tx_data <= bus_wdata[BYTE_W-1:0];
        end
    end

    // R7: a transmitted byte never disturbs the stored buffer
    a_r7_buf_kept: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (slot_q[SLOT_BUF] == $past(slot_q[SLOT_BUF])));

    // R7: transmit-active reads 0 once a byte has gone out
    a_r7_txact_low: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !slot_q[SLOT_CTRL][CTRL_TXACT_BIT]);

    // R6: no received byte reaches the buffer in transmit mode
    a_r6_rx_blocked: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && !rx_ready) |=> $stable(flags.rbf) || !$past(rx_valid));

    // R9: misaligned access returns zero
    a_r9_unaligned_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));
endmodule

// File: tb/scs_regif_tb.sv
module scs_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    scs_regif dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq));

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [6:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        rx_data = b; rx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        rd_check("R1 ctrl", 7'h00, 32'h01);
        rd_check("R1 ctrl1", 7'h04, 32'h07);
        rd_check("R1 ctrl2", 7'h08, 32'h00);
        rd_check("R1 status", 7'h0C, 32'h01);
        rd_check("R1 baud", 7'h10, 32'h01);
        rd_check("R1 buffer", 7'h14, 32'h00);
        rd_check("R1 dir", 7'h18, 32'h01);
        rd_check("R1 imask", 7'h1C, 32'h00);
        rd_check("R1 dmamask", 7'h44, 32'h07);
        rd_check("R1 dmaaddr", 7'h38, 32'h00);
        rd_check("R1 tmask", 7'h5C, 32'h01);
        rd_check("R1 null", 7'h60, 32'h60);
        check("R1 irq", irq, 0);
        check("R1 rx_ready", rx_ready, 1);
    endtask

    task automatic t_masks;
        wr(7'h00, 32'h80);          rd_check("R2 ctrl", 7'h00, 32'h81);
        wr(7'h04, 32'hFFFF_FFFF);   rd_check("R2 ctrl1", 7'h04, 32'h3F);
        wr(7'h08, 32'hFFFF_FFFF);   rd_check("R2 ctrl2", 7'h08, 32'h85);
        wr(7'h18, 32'hFFFF_FFFF);   rd_check("R2 dir", 7'h18, 32'h03);
        wr(7'h34, 32'hFFFF_FFFF);   rd_check("R2 dmasts", 7'h34, 32'h07);
        wr(7'h38, 32'hFFFF_FFFF);   rd_check("R2 dmaaddr", 7'h38, 32'hFF_FFFF);
        wr(7'h3C, 32'hFFFF_FFFF);   rd_check("R2 dmalen", 7'h3C, 32'h1FF);
        wr(7'h40, 32'hFFFF_FFFF);   rd_check("R2 dmaptr", 7'h40, 32'h00);
        wr(7'h50, 32'hFFFF_FFFF);   rd_check("R2 tctl", 7'h50, 32'h0F);
        wr(7'h58, 32'hFFFF_FFFF);   rd_check("R2 treload", 7'h58, 32'hFFFF);
        wr(7'h60, 32'hFFFF_FFFF);   rd_check("R2 null", 7'h60, 32'hFF);
        wr(7'h10, 32'hFFFF_FFFF);   rd_check("R2 baud", 7'h10, 32'hFF);
        wr(7'h14, 32'hFFFF_FF5A);   rd_check("R2 buffer", 7'h14, 32'h5A);
        wr(7'h1C, 32'hFFFF_FFFF);   rd_check("R2 imask", 7'h1C, 32'h8F);
        check("R8 irq from tbe", irq, 1);
        wr(7'h1C, 32'h0);
        check("R8 irq masked off", irq, 0);
    endtask

    task automatic t_rx;
        send(8'h3C);
        rd_check("R3 status full", 7'h0C, 32'h03);
        rd_check("R3 buffer data", 7'h14, 32'h3C);
        rd_check("R3 status emptied", 7'h0C, 32'h01);
    endtask

    task automatic t_overrun;
        send(8'h11);
        send(8'h22);
        rd_check("R4 status overrun", 7'h0C, 32'h0B);
        rd_check("R4 buffer overwritten", 7'h14, 32'h22);
        rd_check("R4 ovr survives read", 7'h0C, 32'h09);
        wr(7'h0C, 32'h02);
        rd_check("R5 rbf/ovr not cleared by 0 in bit3", 7'h0C, 32'h09);
        wr(7'h0C, 32'h08);
        rd_check("R5 w1c overrun", 7'h0C, 32'h01);
        wr(7'h0C, 32'h0);
        rd_check("R5 tbe kept", 7'h0C, 32'h01);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        send(8'h44);
        @(negedge clk);
        bus_addr = 7'h14; bus_re = 1'b1; rx_data = 8'h55; rx_valid = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0; rx_valid = 1'b0;
        check("R11 old byte returned", v, 32'h44);
        rd_check("R11 status full+ovr", 7'h0C, 32'h0B);
        rd_check("R11 new byte", 7'h14, 32'h55);
        wr(7'h0C, 32'h08);
    endtask

    task automatic t_irq;
        wr(7'h1C, 32'h02);
        check("R8 irq low", irq, 0);
        send(8'h66);
        check("R8 irq on rbf", irq, 1);
        rd_check("R8 buffer", 7'h14, 32'h66);
        check("R8 irq after read", irq, 0);
        wr(7'h1C, 32'h0);
    endtask

    task automatic t_tx;
        wr(7'h00, 32'h20);
        check("R6 rx_ready low", rx_ready, 0);
        send(8'h77);
        rd_check("R6 status unchanged", 7'h0C, 32'h01);
        rd_check("R6 buffer unchanged", 7'h14, 32'h66);
        @(negedge clk);
        bus_addr = 7'h14; bus_wdata = 32'h1A5; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        check("R7 tx_valid", tx_valid, 1);
        check("R7 tx_data", tx_data, 8'hA5);
        @(negedge clk);
        check("R7 tx_valid one cycle", tx_valid, 0);
        rd_check("R7 buffer kept", 7'h14, 32'h66);
        @(negedge clk);
        bus_addr = 7'h10; bus_wdata = 32'h5A; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        check("R7 baud tx_data", tx_data, 8'h5A);
        check("R7 baud tx_valid", tx_valid, 1);
        rd_check("R7 baud kept", 7'h10, 32'hFF);
        rd_check("R7 ctrl bit4 low", 7'h00, 32'h21);
        wr(7'h00, 32'h0);
        check("R6 rx_ready back", rx_ready, 1);
    endtask

    task automatic t_odd_access;
        send(8'h99);
        rd_check("R9 unaligned buffer read", 7'h15, 32'h0);
        rd_check("R9 rbf kept", 7'h0C, 32'h03);
        wr(7'h1D, 32'hFF);
        rd_check("R9 unaligned write ignored", 7'h1C, 32'h00);
        wr(7'h20, 32'hFFFF_FFFF);
        rd_check("R10 hole 0x20", 7'h20, 32'h0);
        wr(7'h48, 32'hFFFF_FFFF);
        rd_check("R10 hole 0x48", 7'h48, 32'h0);
        rd_check("R10 hole 0x7C", 7'h7C, 32'h0);
        check("R10 irq quiet", irq, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masks();
        t_rx();
        t_overrun();
        t_same_cycle();
        t_irq();
        t_tx();
        t_odd_access();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule